// File: doc/BRIEF.md
# Decode-Stage Branch and Hazard Controller

This block decides, every cycle, whether a five-stage in-order integer pipeline may advance and where the next fetch comes from. Conditional branches are compared and their targets formed in the decode stage. Fetch assumes every branch falls through. When a branch turns out to be taken, the block redirects the program counter and turns the wrongly fetched instruction into a no-op.

The block stalls decode whenever an operand would not be ready in time. A load followed directly by a consumer costs one bubble. A branch waits one cycle behind an ALU producer and two cycles behind a load producer. A load sitting two slots ahead of a branch costs one more cycle. A stall always wins over a flush, so a branch is only evaluated once its operands can be forwarded. The register file, ALU, memories and forwarding multiplexers sit outside the block. The block takes register numbers and flags from the decode stage and from the two stages after it.

Top module: `hazard_branch_unit`

## Requirements
- R1: When the EX-slot instruction is a load (ex_is_load=1, ex_reg_write=1) whose nonzero destination equals a decode source marked used, the block stalls: pc_we=0, ifid_we=0, idex_bubble=1.
- R2: When decode holds a branch and the EX-slot instruction is a non-load register writer whose nonzero destination matches a used branch source, the block stalls. In a pipeline this costs exactly one stall cycle.
- R3: A load directly ahead of a branch that writes a used branch source costs exactly two stall cycles. The first is with the load in the EX slot and the second with it in the MEM slot.
- R4: A load in the MEM slot (mem_is_load=1, mem_reg_write=1) whose nonzero destination matches a used source stalls a branch in decode, but never stalls a non-branch.
- R5: A destination register number of 0 never causes a stall.
- R6: A source with its used flag at 0 never causes a stall.
- R7: A branch with id_regs_equal=0, or any non-branch, gives pc_sel=0 and ifid_flush=0. With no hazard present, it gives pc_we=1 and ifid_we=1.
- R8: A branch with id_regs_equal=1 and no stall gives pc_sel=1 (fetch from target), ifid_flush=1, pc_we=1 and idex_bubble=0.
- R9: While a stall is present, pc_sel=0 and ifid_flush=0 whatever the compare result.
- R10: branch_target equals id_pc_plus4 plus the sign-extended 16-bit id_offset shifted left by two, modulo 2^XLEN.
- R11: While rst_n is low, and in the cycle before the first clock edge that samples rst_n high, the block freezes the pipeline: pc_we=0, ifid_we=0, idex_bubble=1, ifid_flush=0, pc_sel=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| id_rs | input | REG_AW | First decode source register number |
| id_rt | input | REG_AW | Second decode source register number |
| id_rs_used | input | 1 | First source is read by the decode instruction |
| id_rt_used | input | 1 | Second source is read by the decode instruction |
| id_is_branch | input | 1 | Decode instruction is a branch-on-equal |
| id_regs_equal | input | 1 | Decode-stage compare result (operands equal) |
| id_pc_plus4 | input | XLEN | Address of the decode instruction plus four |
| id_offset | input | 16 | Branch word offset from the instruction |
| ex_dst | input | REG_AW | Destination register of the EX-slot instruction |
| ex_reg_write | input | 1 | EX-slot instruction writes a register |
| ex_is_load | input | 1 | EX-slot instruction is a load |
| mem_dst | input | REG_AW | Destination register of the MEM-slot instruction |
| mem_reg_write | input | 1 | MEM-slot instruction writes a register |
| mem_is_load | input | 1 | MEM-slot instruction is a load |
| pc_we | output | 1 | Program counter update enable |
| ifid_we | output | 1 | Fetch/decode register update enable |
| idex_bubble | output | 1 | Load all-zero control into decode/execute register |
| ifid_flush | output | 1 | Clear the fetch/decode register to a no-op |
| pc_sel | output | 1 | Next PC source: 0 sequential, 1 branch target |
| branch_target | output | XLEN | Computed branch destination |

## Verification
Some properties are checked on every cycle. A stall freezes both enables, and a stall suppresses any flush or redirect. A matching load in the EX slot always bubbles, and a taken, unstalled branch always redirects while a not-taken one never does. The target keeps the word alignment of PC+4. The exact stall counts per producer type (one for an ALU producer, two for a load ahead of a branch, one for a load two ahead) are multi-cycle outcomes, and so are the redirect that follows them. Only the bench's small pipeline model can show these, because it moves producers through the EX and MEM slots as bubbles enter. The bench also sweeps every input combination of a two-bit register space.

// File: rtl/hz_pkg.sv
// Package hz_pkg
// Shared types for the decode-stage hazard and branch controller.
// Assumes nothing beyond the standard language.
package hz_pkg;
    // Next-PC source selector as driven on pc_sel.
    typedef enum logic {
        PC_SEQ    = 1'b0,
        PC_BRANCH = 1'b1
    } pc_src_e;

    // Width of the branch offset field carried by the instruction.
    localparam int unsigned OFFSET_W = 16;
endpackage

// File: rtl/hz_match.sv
// Module hz_match
// Reports whether a producing stage writes a register that the decode
// instruction reads. Assumes register 0 is hardwired to zero, so a zero
// destination never matches; sources flagged unused never match.
module hz_match #(
    parameter int unsigned REG_AW = 5,
    parameter int unsigned NSRC   = 2
) (
    input  logic [NSRC-1:0][REG_AW-1:0] src,
    input  logic [NSRC-1:0]             src_used,
    input  logic [REG_AW-1:0]           dst,
    input  logic                        dst_write,
    output logic                        hit
);
    logic [NSRC-1:0] per_src;
    logic            dst_live;

    // A producer counts only if it writes and its target is not register 0.
    always_comb dst_live = dst_write && (dst != '0);

    // One comparator per decode source.
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        always_comb per_src[i] = dst_live && src_used[i] && (src[i] == dst);
    end

    // Any matching source raises the hit.
    always_comb hit = |per_src;
endmodule

// File: rtl/hz_target.sv
// Module hz_target
// Forms the branch destination from the decode PC+4 and the word offset.
// Assumes XLEN is wider than the offset plus two bits.
module hz_target #(
    parameter int unsigned XLEN = 32,
    parameter int unsigned OFFW = 16
) (
    input  logic [XLEN-1:0] pc_plus4,
    input  logic [OFFW-1:0] offset,
    output logic [XLEN-1:0] target
);
    localparam int unsigned EXT_W = XLEN - OFFW - 2;

    logic [XLEN-1:0] byte_disp;

    // Sign-extend the word offset and scale it to bytes.
    always_comb byte_disp = {{EXT_W{offset[OFFW-1]}}, offset, 2'b00};

    // Add the displacement to the sequential address.
    always_comb target = pc_plus4 + byte_disp;
endmodule

// File: rtl/hz_ctrl.sv
// Module hz_ctrl
// Turns the producer-match flags into pipeline enables, bubble, flush
// and next-PC select. A stall always beats a taken branch. Assumes the
// match flags already exclude register 0 and unused sources.
module hz_ctrl
    import hz_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    is_branch,
    input  logic    regs_equal,
    input  logic    ex_hit,
    input  logic    ex_is_load,
    input  logic    mem_hit,
    input  logic    mem_is_load,
    output logic    pc_we,
    output logic    ifid_we,
    output logic    idex_bubble,
    output logic    ifid_flush,
    output pc_src_e pc_src
);
    logic live_q;
    logic load_use;
    logic br_after_alu;
    logic br_after_far_load;
    logic stall;
    logic hold;
    logic taken;

    // Records that reset has been released for at least one edge.
    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    // Classify the hazard sources present this cycle.
    always_comb begin
        load_use          = ex_hit && ex_is_load;
        br_after_alu      = is_branch && ex_hit && !ex_is_load;
        br_after_far_load = is_branch && mem_hit && mem_is_load;
        stall             = load_use || br_after_alu || br_after_far_load;
    end

    // Freeze during reset or a stall; resolve the branch otherwise.
    always_comb begin
        hold        = stall || !live_q;
        taken       = live_q && !stall && is_branch && regs_equal;
        pc_we       = !hold;
        ifid_we     = !hold;
        idex_bubble = hold;
        ifid_flush  = taken;
        pc_src      = taken ? PC_BRANCH : PC_SEQ;
    end
endmodule

// File: rtl/hazard_branch_unit.sv
// Module hazard_branch_unit
// Decode-stage hazard and branch controller for a five-stage in-order
// pipeline with predict-not-taken fetch. Assumes forwarding into the
// decode comparator from EX/MEM and MEM/WB exists outside this block.
module hazard_branch_unit
    import hz_pkg::*;
#(
    parameter int unsigned REG_AW = 5,
    parameter int unsigned XLEN   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] id_rs,
    input  logic [REG_AW-1:0] id_rt,
    input  logic              id_rs_used,
    input  logic              id_rt_used,
    input  logic              id_is_branch,
    input  logic              id_regs_equal,
    input  logic [XLEN-1:0]   id_pc_plus4,
    input  logic [15:0]       id_offset,
    input  logic [REG_AW-1:0] ex_dst,
    input  logic              ex_reg_write,
    input  logic              ex_is_load,
    input  logic [REG_AW-1:0] mem_dst,
    input  logic              mem_reg_write,
    input  logic              mem_is_load,
    output logic              pc_we,
    output logic              ifid_we,
    output logic              idex_bubble,
    output logic              ifid_flush,
    output logic              pc_sel,
    output logic [XLEN-1:0]   branch_target
);
    localparam int unsigned NSRC = 2;

    logic [NSRC-1:0][REG_AW-1:0] srcs;
    logic [NSRC-1:0]             used;
    logic                        ex_hit;
    logic                        mem_hit;
    pc_src_e                     src_sel;

    // Gather the decode sources into one indexed bundle.
    always_comb begin
        srcs = {id_rt, id_rs};
        used = {id_rt_used, id_rs_used};
    end

    hz_match #(.REG_AW(REG_AW), .NSRC(NSRC)) u_ex_match (
        .src(srcs), .src_used(used), .dst(ex_dst),
        .dst_write(ex_reg_write), .hit(ex_hit)
    );

    hz_match #(.REG_AW(REG_AW), .NSRC(NSRC)) u_mem_match (
        .src(srcs), .src_used(used), .dst(mem_dst),
        .dst_write(mem_reg_write), .hit(mem_hit)
    );

    hz_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .is_branch(id_is_branch), .regs_equal(id_regs_equal),
        .ex_hit(ex_hit), .ex_is_load(ex_is_load),
        .mem_hit(mem_hit), .mem_is_load(mem_is_load),
        .pc_we(pc_we), .ifid_we(ifid_we), .idex_bubble(idex_bubble),
        .ifid_flush(ifid_flush), .pc_src(src_sel)
    );

    hz_target #(.XLEN(XLEN), .OFFW(OFFSET_W)) u_target (
        .pc_plus4(id_pc_plus4), .offset(id_offset), .target(branch_target)
    );

    // Present the selector as a plain bit at the boundary.
    always_comb pc_sel = (src_sel == PC_BRANCH);
endmodule

// File: rtl/hazard_branch_unit_chk.sv
// Module hazard_branch_unit_chk
// Cycle-by-cycle properties of the hazard controller, bound to every
// instance of the top module. Assumes a synchronous active-low reset.
module hazard_branch_unit_chk #(
    parameter int unsigned REG_AW = 5,
    parameter int unsigned XLEN   = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [REG_AW-1:0] id_rs,
    input logic              id_rs_used,
    input logic              id_is_branch,
    input logic              id_regs_equal,
    input logic [XLEN-1:0]   id_pc_plus4,
    input logic [REG_AW-1:0] ex_dst,
    input logic              ex_reg_write,
    input logic              ex_is_load,
    input logic [REG_AW-1:0] mem_dst,
    input logic              pc_we,
    input logic              ifid_we,
    input logic              idex_bubble,
    input logic              ifid_flush,
    input logic              pc_sel,
    input logic [XLEN-1:0]   branch_target
);
    AST_STALL_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        idex_bubble |-> (!pc_we && !ifid_we)); // R1

    AST_LOAD_USE_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_is_load && ex_reg_write && id_rs_used && ex_dst != '0 && ex_dst == id_rs)
        |-> idex_bubble); // R1

    AST_STALL_BEATS_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        idex_bubble |-> (!ifid_flush && !pc_sel)); // R9

    AST_TAKEN_REDIRECTS: assert property (@(posedge clk) disable iff (!rst_n)
        (id_is_branch && id_regs_equal && !idex_bubble) |-> (pc_sel && ifid_flush)); // R8

    AST_NOT_TAKEN_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!id_is_branch || !id_regs_equal) |-> (!pc_sel && !ifid_flush)); // R7

    AST_ZERO_DST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ex_dst == '0 && mem_dst == '0) |-> !idex_bubble); // R5

    AST_TARGET_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        branch_target[1:0] == id_pc_plus4[1:0]); // R10
endmodule

bind hazard_branch_unit hazard_branch_unit_chk #(.REG_AW(REG_AW), .XLEN(XLEN)) u_chk (
    .clk(clk), .rst_n(rst_n), .id_rs(id_rs), .id_rs_used(id_rs_used),
    .id_is_branch(id_is_branch), .id_regs_equal(id_regs_equal),
    .id_pc_plus4(id_pc_plus4), .ex_dst(ex_dst), .ex_reg_write(ex_reg_write),
    .ex_is_load(ex_is_load), .mem_dst(mem_dst), .pc_we(pc_we),
    .ifid_we(ifid_we), .idex_bubble(idex_bubble), .ifid_flush(ifid_flush),
    .pc_sel(pc_sel), .branch_target(branch_target)
);

// File: tb/tb_hazard_branch_unit.sv
// Bench for hazard_branch_unit: exhaustive sweep of a 2-bit register
// space, then a small pipeline model measuring stall counts per case.
module tb_hazard_branch_unit;
    localparam int    CLK_PERIOD = 10;
    localparam int    AW         = 2;
    localparam int    XL         = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] id_rs = '0, id_rt = '0, ex_dst = '0, mem_dst = '0;
    logic          id_rs_used = 0, id_rt_used = 0, id_is_branch = 0, id_regs_equal = 0;
    logic          ex_reg_write = 0, ex_is_load = 0, mem_reg_write = 0, mem_is_load = 0;
    logic [XL-1:0] id_pc_plus4 = '0;
    logic [15:0]   id_offset = '0;
    logic          pc_we, ifid_we, idex_bubble, ifid_flush, pc_sel;
    logic [XL-1:0] branch_target;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hazard_branch_unit #(.REG_AW(AW), .XLEN(XL)) dut (
        .clk(clk), .rst_n(rst_n), .id_rs(id_rs), .id_rt(id_rt),
        .id_rs_used(id_rs_used), .id_rt_used(id_rt_used),
        .id_is_branch(id_is_branch), .id_regs_equal(id_regs_equal),
        .id_pc_plus4(id_pc_plus4), .id_offset(id_offset),
        .ex_dst(ex_dst), .ex_reg_write(ex_reg_write), .ex_is_load(ex_is_load),
        .mem_dst(mem_dst), .mem_reg_write(mem_reg_write), .mem_is_load(mem_is_load),
        .pc_we(pc_we), .ifid_we(ifid_we), .idex_bubble(idex_bubble),
        .ifid_flush(ifid_flush), .pc_sel(pc_sel), .branch_target(branch_target)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    endtask

    // Drive a pipeline snapshot after the edge, sample at the falling edge.
    task automatic step();
        @(posedge clk); #1;
    endtask

    // Pipeline scenario: branch or consumer in decode reading r1 and r2,
    // producer placed in EX or MEM; producers advance one slot per stall.
    task automatic scenario(input string req, input bit br, input bit eq,
                            input bit in_mem, input logic [AW-1:0] d,
                            input bit ld, input int exp_stalls);
        int stalls = 0;
        logic [XL-1:0] exp_tgt;
        step();
        id_rs = 2'd1; id_rt = 2'd2; id_rs_used = 1; id_rt_used = 1;
        id_is_branch = br; id_regs_equal = eq;
        id_pc_plus4 = 32'h0000_0104; id_offset = 16'hFFFC;
        exp_tgt = 32'h0000_0104 - 32'd16;
        ex_dst = in_mem ? '0 : d; ex_reg_write = !in_mem; ex_is_load = !in_mem && ld;
        mem_dst = in_mem ? d : '0; mem_reg_write = in_mem; mem_is_load = in_mem && ld;
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            if (!idex_bubble) break;
            stalls++;
            step();
            mem_dst = ex_dst; mem_reg_write = ex_reg_write; mem_is_load = ex_is_load;
            ex_dst = '0; ex_reg_write = 0; ex_is_load = 0;
        end
        check({req, " stall count"}, 64'(stalls), 64'(exp_stalls));
        check({req, " advance"}, {pc_we, ifid_we}, 2'b11);
        check({req, " flush"}, 64'(ifid_flush), 64'(br && eq));
        check({req, " next pc sel"}, 64'(pc_sel), 64'(br && eq));
        check({req, " target"}, 64'(branch_target), 64'(exp_tgt));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        // R11: frozen while reset is asserted.
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R11 reset freeze", {pc_we, ifid_we, idex_bubble, ifid_flush, pc_sel}, 5'b00100);
        #1 rst_n = 1'b1; id_is_branch = 1; id_regs_equal = 1;
        @(negedge clk);
        check("R11 first live edge", {pc_we, ifid_we, idex_bubble, ifid_flush, pc_sel}, 5'b11011);

        // Exhaustive sweep over registers and flags.
        for (int v = 0; v < 65536; v++) begin
            logic hit_ex, hit_mem, stall, tk;
            logic [XL-1:0] exp_tgt;
            step();
            id_rs = v[1:0]; id_rt = v[3:2]; ex_dst = v[5:4]; mem_dst = v[7:6];
            ex_reg_write = v[8]; ex_is_load = v[9]; mem_reg_write = v[10]; mem_is_load = v[11];
            id_is_branch = v[12]; id_regs_equal = v[13]; id_rs_used = v[14]; id_rt_used = v[15];
            id_pc_plus4 = (32'(v) << 2) ^ 32'h1000_0004;
            id_offset = 16'(v * 40503);
            hit_ex = ex_reg_write && ex_dst != 0 &&
                     ((id_rs_used && id_rs == ex_dst) || (id_rt_used && id_rt == ex_dst));
            hit_mem = mem_reg_write && mem_dst != 0 &&
                      ((id_rs_used && id_rs == mem_dst) || (id_rt_used && id_rt == mem_dst));
            stall = (hit_ex && (ex_is_load || id_is_branch)) ||
                    (hit_mem && mem_is_load && id_is_branch);
            tk = id_is_branch && id_regs_equal && !stall;
            exp_tgt = id_pc_plus4 + (32'($signed(id_offset)) << 2);
            @(negedge clk);
            // R1 R2 R4 R5 R6: stall decision; R7 R8 R9: redirect decision.
            check("R1 R2 R4 R5 R6 stall", {pc_we, ifid_we, idex_bubble}, {!stall, !stall, stall});
            check("R7 R8 R9 redirect", {ifid_flush, pc_sel}, {tk, tk});
            check("R10 target", 64'(branch_target), 64'(exp_tgt));
        end

        // Pipeline scenarios: stall counts, flush, next PC.
        scenario("R7 no producer not taken", 1, 0, 0, 2'd3, 0, 0);
        scenario("R8 no producer taken",     1, 1, 0, 2'd3, 0, 0);
        scenario("R2 ALU then branch taken", 1, 1, 0, 2'd1, 0, 1);
        scenario("R2 ALU then branch not taken", 1, 0, 0, 2'd2, 0, 1);
        scenario("R3 load then branch taken", 1, 1, 0, 2'd2, 1, 2);
        scenario("R3 load then branch not taken", 1, 0, 0, 2'd1, 1, 2);
        scenario("R4 load two ahead of branch", 1, 1, 1, 2'd1, 1, 1);
        scenario("R4 far load non-branch", 0, 0, 1, 2'd1, 1, 0);
        scenario("R1 load then use", 0, 0, 0, 2'd2, 1, 1);
        scenario("R5 load writing r0", 1, 1, 0, 2'd0, 1, 0);

        // R6: unused source cannot stall.
        step();
        id_rs_used = 0; id_rt_used = 0; ex_dst = 2'd1; ex_reg_write = 1; ex_is_load = 1;
        id_is_branch = 0;
        @(negedge clk);
        check("R6 unused sources", {pc_we, idex_bubble}, 2'b10);

        finish_run();
    end
endmodule